// File: doc/BRIEF.md
# Serial PCM Receive Deserialiser with Attenuation Code

This block turns the serial receive stream of a voice-band PCM port into one parallel 13-bit two's-complement sample per frame, ready for a DAC. All port pins are sampled by a fast internal reference clock. Bit clock and frame sync edges are found in that clock domain. The frame sync is classed as short (high at one bit-clock falling edge) or long (still high at the next falling edge). Data bits are taken most significant bit first on the falling edges of the bit clock.

When the receive bit clock pin stops toggling, its static level selects one of two 16-bit word formats, and timing then comes from the transmit bit clock. Held low, the word carries the sign repeated three extra times in front of the sample. Held high, the word carries the sample followed by a 3-bit attenuation code, where each code step means 3 dB more loss (000 = 0 dB, 111 = 21 dB). If transmit frames keep arriving while no receive frame sync appears, the sample is forced to mid-scale zero so that the analog path sees no stale value.

The sample leaves on a valid/ready stream. The serial line cannot be paused, so back-pressure never stalls reception. A word that the consumer has not accepted stays on the port with valid high. A newer word replaces it, and the older one is lost.

Top module: `pcm_rx_port`

## Requirements
- R1: After reset, smp_valid is 0, smp_data is 0, atten_code is 0, rx_mode is 0 and frame_long is 0.
- R2: In standard mode (rx_mode = 0, receive bit clock toggling), 13 bits are taken on falling edges of bclk_rx, first bit = sign = smp_data[12]. Exactly one word per frame is presented with smp_valid.
- R3: A bit clock pin with no edge for STATIC_CYC (64) reference cycles is static. Static low selects sign-extended mode (rx_mode = 1), static high selects gain mode (rx_mode = 2), and both take bit timing from bclk_tx.
- R4: A frame sync seen high at exactly one falling edge is short. The first data bit is taken at the next falling edge, and frame_long reads 0.
- R5: A frame sync still high at the second falling edge is long. The first data bit is the one taken at the falling edge where sync was first seen high, and frame_long reads 1.
- R6: Bits arriving after the last bit of the word (13th, or 16th in the 16-bit modes) produce no further sample until the next frame sync rising edge.
- R7: In sign-extended mode a 16-bit word is received, and smp_data is its last 13 bits (bits 4 to 16).
- R8: In gain mode a 16-bit word is received. smp_data is bits 1 to 13, and atten_code is bits 14 to 16, with bit 14 as atten_code[2]. A word completed in any other mode sets atten_code to 0.
- R9: smp_valid stays high with smp_data unchanged until smp_ready is seen high. A new word arriving before that replaces the pending one.
- R10: After MUTE_FRAMES (2) rising edges of fs_tx with no rising edge of fs_rx, smp_data reads 0. The next fs_rx rising edge ends the muting.
- R11: rx_mode changes only at a frame sync detection. A newly detected clock state takes effect at the next frame, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock, much faster than the bit clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_rx | input | 1 | Receive bit clock, or static mode-select level |
| bclk_tx | input | 1 | Transmit bit clock, used for timing in the 16-bit modes |
| fs_rx | input | 1 | Receive frame sync |
| fs_tx | input | 1 | Transmit frame sync, watched for muting |
| sdin | input | 1 | Serial receive data |
| smp_data | output | 13 | Received two's-complement sample |
| smp_valid | output | 1 | Sample stream valid |
| smp_ready | input | 1 | Sample stream ready from the consumer |
| atten_code | output | 3 | Receive attenuation code, 3 dB per step |
| rx_mode | output | 2 | Word format in use: 0 standard, 1 sign-extended, 2 gain |
| frame_long | output | 1 | Last frame sync was long |

## Verification
The hardest situation to reach is a word-format change. The receive bit clock has to stay silent for the full static window while the transmit bit clock keeps running, and only the following frame sync may switch the format. The stimulus freezes bclk_rx at a chosen level and runs a dozen idle bit periods. It checks that rx_mode has not yet moved, and only then sends a frame. Muting is reached the same way, with transmit frame syncs pulsed while the receive sync stays low. Overwrite is reached by holding smp_ready low across two frames.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;

  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_SEXT = 2'd1,
    MODE_GAIN = 2'd2
  } rx_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } deser_st_e;

  localparam int DEF_SAMPLE_W = 13;
  localparam int DEF_CODE_W   = 3;

endpackage

// File: rtl/pcmrx_sync.sv
module pcmrx_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/pcmrx_clkmon.sv
module pcmrx_clkmon
  import pcmrx_pkg::*;
#(
  parameter int STATIC_CYC = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lvl,
  output rx_mode_e pend_mode
);

  localparam int CNT_W = $clog2(STATIC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STATIC_CYC - 1);

  logic             lvl_q;
  logic             static_q;
  logic [CNT_W-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= 1'b0;
      static_q  <= 1'b0;
      quiet_cnt <= '0;
    end else begin
      lvl_q <= lvl;
      if (lvl != lvl_q) begin
        quiet_cnt <= '0;
        static_q  <= 1'b0;
      end else if (quiet_cnt == CNT_LAST) begin
        static_q  <= 1'b1;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (!static_q)  pend_mode = MODE_STD;
    else if (lvl_q) pend_mode = MODE_GAIN;
    else            pend_mode = MODE_SEXT;
  end

  // R3
  static_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(static_q) |-> $stable(lvl_q));

endmodule

// File: rtl/pcmrx_deser.sv
module pcmrx_deser
  import pcmrx_pkg::*;
#(
  parameter int SAMPLE_W = 13,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              fs,
  input  logic              sd,
  input  rx_mode_e          pend_mode,
  output rx_mode_e          cur_mode,
  output logic              frame_long,
  output logic              word_stb,
  output logic [WORD_W-1:0] word_q
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  deser_st_e         st;
  logic              sclk_q;
  logic              fs_last;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  len_q;
  logic [CNT_W-1:0]  len_nxt;
  logic [WORD_W-1:0] shift_nxt;
  logic [WORD_W-1:0] first_bit;
  logic              fall;
  logic              sync_hit;

  assign fall      = sclk_q & ~sclk;
  assign sync_hit  = fall & fs & ~fs_last;
  assign cnt_inc   = cnt + 1'b1;
  assign shift_nxt = {shreg[WORD_W-2:0], sd};
  assign first_bit = {{(WORD_W-1){1'b0}}, sd};
  assign len_nxt   = (pend_mode == MODE_STD) ? CNT_W'(SAMPLE_W) : CNT_W'(WORD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      sclk_q     <= 1'b0;
      fs_last    <= 1'b0;
      shreg      <= '0;
      cnt        <= '0;
      len_q      <= CNT_W'(SAMPLE_W);
      cur_mode   <= MODE_STD;
      frame_long <= 1'b0;
      word_stb   <= 1'b0;
      word_q     <= '0;
    end else begin
      word_stb <= 1'b0;
      sclk_q   <= sclk;
      if (fall) begin
        fs_last <= fs;
        if (fs && !fs_last) begin
          st       <= ST_SYNC;
          shreg    <= first_bit;
          cnt      <= CNT_W'(1);
          cur_mode <= pend_mode;
          len_q    <= len_nxt;
        end else begin
          case (st)
            ST_SYNC: begin
              st         <= ST_DATA;
              frame_long <= fs;
              if (fs) begin
                shreg <= shift_nxt;
                cnt   <= CNT_W'(2);
              end else begin
                shreg <= first_bit;
                cnt   <= CNT_W'(1);
              end
            end
            ST_DATA: begin
              shreg <= shift_nxt;
              cnt   <= cnt_inc;
              if (cnt_inc == len_q) begin
                st       <= ST_IDLE;
                word_stb <= 1'b1;
                word_q   <= shift_nxt;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R6
  bitcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= len_q);

  // R11
  mode_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_mode) |-> $past(sync_hit));

  // R2
  stb_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> $past(st) == ST_DATA);

endmodule

// File: rtl/pcmrx_mute.sv
module pcmrx_mute #(
  parameter int MUTE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_rx,
  input  logic fs_tx,
  output logic muted
);

  localparam int CW = $clog2(MUTE_FRAMES + 1);
  localparam logic [CW-1:0] CMAX = CW'(MUTE_FRAMES);

  logic          rx_q, tx_q;
  logic          rx_rise, tx_rise;
  logic [CW-1:0] miss_cnt;

  assign rx_rise = fs_rx & ~rx_q;
  assign tx_rise = fs_tx & ~tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= 1'b0;
      tx_q     <= 1'b0;
      miss_cnt <= '0;
    end else begin
      rx_q <= fs_rx;
      tx_q <= fs_tx;
      if (rx_rise)                           miss_cnt <= '0;
      else if (tx_rise && miss_cnt != CMAX)  miss_cnt <= miss_cnt + 1'b1;
    end
  end

  assign muted = (miss_cnt == CMAX);

  // R10
  mute_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rise |=> !muted);

endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port
  import pcmrx_pkg::*;
#(
  parameter int SAMPLE_W    = DEF_SAMPLE_W,
  parameter int CODE_W      = DEF_CODE_W,
  parameter int SYNC_STAGES = 2,
  parameter int STATIC_CYC  = 64,
  parameter int MUTE_FRAMES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_rx,
  input  logic                bclk_tx,
  input  logic                fs_rx,
  input  logic                fs_tx,
  input  logic                sdin,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_valid,
  input  logic                smp_ready,
  output logic [CODE_W-1:0]   atten_code,
  output logic [1:0]          rx_mode,
  output logic                frame_long
);

  localparam int WORD_W = SAMPLE_W + CODE_W;

  logic [4:0]          pins_s;
  logic                bclk_rx_s, bclk_tx_s, fs_rx_s, fs_tx_s, sdin_s;
  logic                sclk_sel;
  rx_mode_e            pend_mode;
  rx_mode_e            cur_mode;
  logic                word_stb;
  logic [WORD_W-1:0]   word_q;
  logic                muted;
  logic [SAMPLE_W-1:0] data_q;
  logic [SAMPLE_W-1:0] data_dec;
  logic                valid_q;
  logic [CODE_W-1:0]   atten_q;

  pcmrx_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({bclk_rx, bclk_tx, fs_rx, fs_tx, sdin}),
    .dout (pins_s)
  );
  assign {bclk_rx_s, bclk_tx_s, fs_rx_s, fs_tx_s, sdin_s} = pins_s;

  pcmrx_clkmon #(.STATIC_CYC(STATIC_CYC)) u_clkmon (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (bclk_rx_s),
    .pend_mode(pend_mode)
  );

  assign sclk_sel = (pend_mode == MODE_STD) ? bclk_rx_s : bclk_tx_s;

  pcmrx_deser #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk_sel),
    .fs        (fs_rx_s),
    .sd        (sdin_s),
    .pend_mode (pend_mode),
    .cur_mode  (cur_mode),
    .frame_long(frame_long),
    .word_stb  (word_stb),
    .word_q    (word_q)
  );

  pcmrx_mute #(.MUTE_FRAMES(MUTE_FRAMES)) u_mute (
    .clk  (clk),
    .rst_n(rst_n),
    .fs_rx(fs_rx_s),
    .fs_tx(fs_tx_s),
    .muted(muted)
  );

  assign data_dec = (cur_mode == MODE_GAIN) ? word_q[WORD_W-1:CODE_W]
                                            : word_q[SAMPLE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      atten_q <= '0;
    end else if (word_stb) begin
      data_q  <= data_dec;
      valid_q <= 1'b1;
      atten_q <= (cur_mode == MODE_GAIN) ? word_q[CODE_W-1:0] : '0;
    end else if (valid_q && smp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign smp_data   = muted ? '0 : data_q;
  assign smp_valid  = valid_q;
  assign atten_code = atten_q;
  assign rx_mode    = cur_mode;

  // R9
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && !word_stb) |=> (smp_valid && $stable(data_q)));

  // R8
  atten_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && cur_mode != MODE_GAIN) |=> (atten_code == '0));

endmodule

// File: tb/pcm_rx_port_tb.sv
module pcm_rx_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_rx = 1'b0, bclk_tx = 1'b0, fs_rx = 1'b0, fs_tx = 1'b0, sdin = 1'b0;
  logic        smp_ready = 1'b1;
  logic [12:0] smp_data;
  logic        smp_valid;
  logic [2:0]  atten_code;
  logic [1:0]  rx_mode;
  logic        frame_long;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit rx_static = 0;
  bit rx_lvl = 0;

  typedef struct {
    logic [12:0] d;
    logic [2:0]  a;
    logic [1:0]  m;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;

  pcm_rx_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_rx(bclk_rx), .bclk_tx(bclk_tx),
    .fs_rx(fs_rx), .fs_tx(fs_tx), .sdin(sdin), .smp_data(smp_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .atten_code(atten_code),
    .rx_mode(rx_mode), .frame_long(frame_long)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bit period: 4 reference cycles high, 4 low
  task automatic bit_period(input logic d, input logic fsr, input logic fst);
    @(negedge clk);
    bclk_tx = 1'b1;
    bclk_rx = rx_static ? rx_lvl : 1'b1;
    sdin = d; fs_rx = fsr; fs_tx = fst;
    repeat (4) @(negedge clk);
    bclk_tx = 1'b0;
    bclk_rx = rx_static ? rx_lvl : 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n, input bit tx_pulse);
    for (int p = 0; p < n; p++) bit_period(1'b0, 1'b0, tx_pulse && p == 0);
  endtask

  task automatic send_frame(input logic [15:0] w, input int nbits, input bit lng, input bit tx_late);
    for (int p = 0; p < 20; p++) begin
      logic d;
      logic fsr;
      logic fst;
      d = p[0];
      if (lng) begin
        fsr = (p < 3);
        if (p < nbits) d = w[nbits-1-p];
      end else begin
        fsr = (p == 0);
        if (p >= 1 && p <= nbits) d = w[nbits-p];
      end
      fst = tx_late ? (p == 8) : fsr;
      bit_period(d, fsr, fst);
    end
  endtask

  task automatic push(input logic [12:0] d, input logic [2:0] a, input logic [1:0] m, input string tag);
    exp_t e;
    e.d = d; e.a = a; e.m = m; e.tag = tag;
    expq.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && smp_valid && smp_ready) begin
      if (expq.size() == 0) begin
        tests++;
        fails++;
        $display("FAIL R6: actual unexpected sample %0h expected none", smp_data);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk({e.tag, " data"}, 32'(smp_data), 32'(e.d));
        chk({e.tag, " atten"}, 32'(atten_code), 32'(e.a));
        chk({e.tag, " mode"}, 32'(rx_mode), 32'(e.m));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    idle(2, 1'b0);
    // R1 reset state
    chk("R1 valid", 32'(smp_valid), 0);
    chk("R1 data", 32'(smp_data), 0);
    chk("R1 atten", 32'(atten_code), 0);
    chk("R1 mode", 32'(rx_mode), 0);
    chk("R1 long", 32'(frame_long), 0);

    // R2 / R4 standard short frames
    push(13'h1A5C, 3'd0, 2'd0, "R2 R4 short");
    send_frame({3'b0, 13'h1A5C}, 13, 1'b0, 1'b0);
    chk("R4 frame_long", 32'(frame_long), 0);
    push(13'h0F01, 3'd0, 2'd0, "R2 positive");
    send_frame({3'b0, 13'h0F01}, 13, 1'b0, 1'b0);

    // R5 long frame
    push(13'h0ACE, 3'd0, 2'd0, "R5 long");
    send_frame({3'b0, 13'h0ACE}, 13, 1'b1, 1'b0);
    chk("R5 frame_long", 32'(frame_long), 1);

    // R9 back-pressure: hold then overwrite
    smp_ready = 1'b0;
    send_frame({3'b0, 13'h0123}, 13, 1'b0, 1'b0);
    chk("R9 held valid", 32'(smp_valid), 1);
    chk("R9 held data", 32'(smp_data), 32'h0123);
    push(13'h1FFE, 3'd0, 2'd0, "R9 overwrite");
    send_frame({3'b0, 13'h1FFE}, 13, 1'b1, 1'b0);
    chk("R9 replaced data", 32'(smp_data), 32'h1FFE);
    @(negedge clk);
    smp_ready = 1'b1;
    idle(2, 1'b0);

    // R10 muting after two transmit syncs without receive sync
    idle(4, 1'b1);
    chk("R10 one tx sync", 32'(smp_data), 32'h1FFE);
    idle(4, 1'b1);
    chk("R10 muted", 32'(smp_data), 0);
    push(13'h0777, 3'd0, 2'd0, "R10 release");
    send_frame({3'b0, 13'h0777}, 13, 1'b0, 1'b0);

    // R3 / R7 sign-extended: static low receive clock
    rx_static = 1; rx_lvl = 0;
    idle(12, 1'b0);
    chk("R11 mode before frame", 32'(rx_mode), 0);
    push(13'h1C3A, 3'd0, 2'd1, "R7 sext short");
    send_frame({3'b111, 13'h1C3A}, 16, 1'b0, 1'b1);
    chk("R3 sext mode", 32'(rx_mode), 1);
    push(13'h0555, 3'd0, 2'd1, "R7 sext long");
    send_frame({3'b000, 13'h0555}, 16, 1'b1, 1'b1);

    // R3 / R8 gain mode: static high receive clock
    rx_lvl = 1;
    idle(12, 1'b0);
    chk("R11 mode held", 32'(rx_mode), 1);
    push(13'h0B6D, 3'd5, 2'd2, "R8 gain short");
    send_frame({13'h0B6D, 3'b101}, 16, 1'b0, 1'b1);
    chk("R8 atten", 32'(atten_code), 5);
    chk("R3 gain mode", 32'(rx_mode), 2);
    push(13'h1234, 3'd7, 2'd2, "R8 gain long");
    send_frame({13'h1234, 3'b111}, 16, 1'b1, 1'b1);

    // R8 attenuation cleared by a word in another mode
    rx_lvl = 0;
    idle(12, 1'b0);
    push(13'h1001, 3'd0, 2'd1, "R8 clear");
    send_frame({3'b111, 13'h1001}, 16, 1'b0, 1'b1);
    chk("R8 atten cleared", 32'(atten_code), 0);

    // R11 back to standard at next frame
    rx_static = 0;
    idle(3, 1'b0);
    chk("R11 mode until frame", 32'(rx_mode), 1);
    push(13'h0042, 3'd0, 2'd0, "R11 std again");
    send_frame({3'b0, 13'h0042}, 13, 1'b0, 1'b0);
    chk("R11 std mode", 32'(rx_mode), 0);

    idle(4, 1'b0);
    // R6 no extra samples from trailing bits
    chk("R6 queue drained", 32'(expq.size()), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule